// File: doc/BRIEF.md
# DMA Address Remapper with Read-Ahead

This unit sits between a DMA-capable device and the system bus. Every device access carries a 32-bit address. The unit translates it through a small table of 4 KB page mappings into a 40-bit system address, which can reach memory above the 4 GB line. Software loads the table one slot at a time through an indexed write port. Each slot holds these fields:

- a valid flag
- the device page number
- the system page number
- a read permission
- a write permission
- a streaming flag

A cleared streaming flag marks the region as consistent, and that is the default.

A read that hits a streaming region is answered first. The unit then fetches the next line of the same page into a single holding register, so a device walking through a buffer finds its next line waiting. Consistent regions are never read ahead: each of their reads goes to memory when it is asked for. An access that misses the table, or that lacks the needed permission, is answered with an error and never reaches the bus. The unit handles one device access at a time.

Every data-carrying interface uses a valid/ready handshake. The unit holds `dev_req_ready` high only when it is idle. Once a response or a system request is raised, it stays raised with stable contents until it is accepted. System read data is always accepted at once, so it has no ready signal.

Top module: `dma_remap_unit`

## Requirements
- R1: After reset every table slot is invalid, `dev_req_ready` is high, and neither `sys_req_valid` nor `dev_rsp_valid` is asserted.
- R2: A permitted read of device address A in a mapped page issues one system read at {system page number, A[11:0]} and returns that read's data unchanged with `dev_rsp_err` = 0.
- R3: An access whose page matches no valid slot is answered with `dev_rsp_err` = 1 and zero data, and issues no system request.
- R4: A write to a slot whose write permission is 0, or a read from a slot whose read permission is 0, is answered with `dev_rsp_err` = 1 and issues no system request.
- R5: A slot programmed with the streaming flag at 0 (the default, consistent) causes exactly one system read per device read and no read-ahead.
- R6: A read of line L (8-byte lines) in a streaming slot, where L is not the last line of its page, is followed after its response by one system read of the next line's translated address (+8).
- R7: A read of the line currently held is returned from the holding register without a system read for that line.
- R8: A streaming read of the last line of a page (offset 0xFF8) issues no read-ahead.
- R9: The held line is discarded by a table write whose old or new device page equals the held page, and by a device write to the held line; a following read of that line goes to the system bus.
- R10: When several valid slots match one device page, the slot with the lowest index supplies the translation.
- R11: While `dev_rsp_valid` is high and `dev_rsp_ready` is low, the response, its data and its error flag stay unchanged.
- R12: A permitted write issues one system write with the translated address and the device data, holds that request stable until `sys_req_ready`, and then answers with `dev_rsp_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table slot write strobe |
| cfg_idx | input | 4 | Slot index to write |
| cfg_vpn | input | 20 | Device page number for the slot |
| cfg_ppn | input | 28 | System page number for the slot |
| cfg_valid | input | 1 | Slot valid flag |
| cfg_rd_en | input | 1 | Slot read permission |
| cfg_wr_en | input | 1 | Slot write permission |
| cfg_stream | input | 1 | 1 = streaming, 0 = consistent |
| dev_req_valid | input | 1 | Device request valid |
| dev_req_ready | output | 1 | Unit can accept a request |
| dev_req_write | input | 1 | 1 = write, 0 = read |
| dev_req_addr | input | 32 | Device address |
| dev_req_wdata | input | 64 | Device write data |
| dev_rsp_valid | output | 1 | Response valid |
| dev_rsp_ready | input | 1 | Device accepts response |
| dev_rsp_err | output | 1 | Translation or permission error |
| dev_rsp_rdata | output | 64 | Read data |
| sys_req_valid | output | 1 | System request valid |
| sys_req_ready | input | 1 | System bus accepts request |
| sys_req_write | output | 1 | 1 = write, 0 = read |
| sys_req_addr | output | 40 | Translated system address |
| sys_req_wdata | output | 64 | System write data |
| sys_rsp_valid | input | 1 | System read data valid |
| sys_rsp_rdata | input | 64 | System read data |

## Verification
The bench programs all sixteen slots with a mix of permissions and attributes, then sweeps one read and one write per slot. The system bus model returns data computed from the address, so a wrong page number or offset shows up in the data and in the logged bus address. Counting bus requests per access is what separates consistent reads (one request) from streaming reads (request plus read-ahead) and from reads served by the holding register (read-ahead only). Dedicated sequences cover the following:

- the last line of a page
- remapping the held page
- a device write onto the held line
- overlapping slots
- a response held back by the device

// File: rtl/dma_remap_pkg.sv
package dma_remap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUS_REQ,
    ST_BUS_WAIT,
    ST_RESP,
    ST_PF_REQ,
    ST_PF_WAIT
  } remap_state_e;
endpackage

// File: rtl/dma_remap_table.sv
module dma_remap_table #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 28,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_valid,
  input  logic             wr_rd,
  input  logic             wr_wr,
  input  logic             wr_stream,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_rd,
  output logic             lk_wr,
  output logic             lk_stream,
  output logic             old_valid,
  output logic [VPN_W-1:0] old_vpn
);
  logic [ENTRIES-1:0] ent_vld, ent_rd, ent_wr, ent_str;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];
  logic [ENTRIES-1:0] match;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ent_vld <= '0;
    else if (wr_en) ent_vld[wr_idx] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_idx] <= wr_vpn;
      ent_ppn[wr_idx] <= wr_ppn;
      ent_rd[wr_idx]  <= wr_rd;
      ent_wr[wr_idx]  <= wr_wr;
      ent_str[wr_idx] <= wr_stream;
    end
  end

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_match
      assign match[g] = ent_vld[g] && (ent_vpn[g] == lk_vpn);
    end
  endgenerate

  // Scan from the top down so the lowest matching index is applied last.
  always_comb begin
    lk_hit    = 1'b0;
    lk_ppn    = '0;
    lk_rd     = 1'b0;
    lk_wr     = 1'b0;
    lk_stream = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        lk_hit    = 1'b1;
        lk_ppn    = ent_ppn[i];
        lk_rd     = ent_rd[i];
        lk_wr     = ent_wr[i];
        lk_stream = ent_str[i];
      end
    end
  end

  assign old_valid = ent_vld[wr_idx];
  assign old_vpn   = ent_vpn[wr_idx];
endmodule

// File: rtl/dma_remap_hold.sv
module dma_remap_hold #(
  parameter int LINE_W = 29,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [LINE_W-1:0] arm_line,
  input  logic              fill,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              inv,
  output logic              hold_valid,
  output logic [LINE_W-1:0] hold_line,
  output logic [DATA_W-1:0] hold_data
);
  logic pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_valid <= 1'b0;
      pend       <= 1'b0;
    end else if (inv) begin
      hold_valid <= 1'b0;
      pend       <= 1'b0;
    end else if (arm) begin
      hold_valid <= 1'b0;
      pend       <= 1'b1;
    end else if (fill && pend) begin
      hold_valid <= 1'b1;
      pend       <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (arm)  hold_line <= arm_line;
    if (fill) hold_data <= fill_data;
  end
endmodule

// File: rtl/dma_remap_unit.sv
module dma_remap_unit
  import dma_remap_pkg::*;
#(
  parameter int DEV_AW    = 32,
  parameter int SYS_AW    = 40,
  parameter int PAGE_BITS = 12,
  parameter int ENTRIES   = 16,
  parameter int DATA_W    = 64,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int VPN_W    = DEV_AW - PAGE_BITS,
  localparam int PPN_W    = SYS_AW - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [VPN_W-1:0]  cfg_vpn,
  input  logic [PPN_W-1:0]  cfg_ppn,
  input  logic              cfg_valid,
  input  logic              cfg_rd_en,
  input  logic              cfg_wr_en,
  input  logic              cfg_stream,
  input  logic              dev_req_valid,
  output logic              dev_req_ready,
  input  logic              dev_req_write,
  input  logic [DEV_AW-1:0] dev_req_addr,
  input  logic [DATA_W-1:0] dev_req_wdata,
  output logic              dev_rsp_valid,
  input  logic              dev_rsp_ready,
  output logic              dev_rsp_err,
  output logic [DATA_W-1:0] dev_rsp_rdata,
  output logic              sys_req_valid,
  input  logic              sys_req_ready,
  output logic              sys_req_write,
  output logic [SYS_AW-1:0] sys_req_addr,
  output logic [DATA_W-1:0] sys_req_wdata,
  input  logic              sys_rsp_valid,
  input  logic [DATA_W-1:0] sys_rsp_rdata
);
  localparam int LINE_BITS = $clog2(DATA_W / 8);
  localparam int DLINE_W   = DEV_AW - LINE_BITS;
  localparam int SLOT_W    = PAGE_BITS - LINE_BITS;
  localparam logic [DLINE_W-1:0] LINE_ONE = DLINE_W'(1);
  localparam logic [SLOT_W-1:0]  SLOT_ONE = SLOT_W'(1);

  remap_state_e state;

  logic              lk_hit, lk_rd, lk_wr, lk_stream, old_vld;
  logic [PPN_W-1:0]  lk_ppn;
  logic [VPN_W-1:0]  old_vpn;
  logic              hold_valid;
  logic [DLINE_W-1:0] hold_line, track_line, req_line, pf_line;
  logic [DATA_W-1:0] hold_data, lat_data, lat_wdata;
  logic [SYS_AW-1:0] lat_addr, pf_addr;
  logic [PAGE_BITS-1:0] req_off;
  logic [SLOT_W-1:0] nxt_slot;
  logic [VPN_W-1:0]  track_vpn;
  logic lat_err, lat_write, pf_pend;
  logic acc, perm_ok, pf_ok, hold_hit, arm, fill, inv;

  dma_remap_table #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_vpn(cfg_vpn), .wr_ppn(cfg_ppn),
    .wr_valid(cfg_valid), .wr_rd(cfg_rd_en), .wr_wr(cfg_wr_en), .wr_stream(cfg_stream),
    .lk_vpn(dev_req_addr[DEV_AW-1:PAGE_BITS]),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd(lk_rd), .lk_wr(lk_wr), .lk_stream(lk_stream),
    .old_valid(old_vld), .old_vpn(old_vpn)
  );

  dma_remap_hold #(.LINE_W(DLINE_W), .DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .arm(arm), .arm_line(pf_line),
    .fill(fill), .fill_data(sys_rsp_rdata),
    .inv(inv),
    .hold_valid(hold_valid), .hold_line(hold_line), .hold_data(hold_data)
  );

  assign req_line = dev_req_addr[DEV_AW-1:LINE_BITS];
  assign req_off  = dev_req_addr[PAGE_BITS-1:0];
  assign nxt_slot = req_off[PAGE_BITS-1:LINE_BITS] + SLOT_ONE;
  assign acc      = (state == ST_IDLE) && dev_req_valid;
  assign perm_ok  = dev_req_write ? lk_wr : lk_rd;
  assign pf_ok    = lk_stream && !(&req_off[PAGE_BITS-1:LINE_BITS]);
  assign hold_hit = hold_valid && (hold_line == req_line);

  assign arm  = (state == ST_RESP) && dev_rsp_ready && pf_pend;
  assign fill = (state == ST_PF_WAIT) && sys_rsp_valid;

  // Compare against the line about to be armed so a same-cycle table write is not lost.
  assign track_line = arm ? pf_line : hold_line;
  assign track_vpn  = track_line[DLINE_W-1:SLOT_W];
  assign inv = (cfg_we && ((old_vld && (old_vpn == track_vpn)) || (cfg_vpn == track_vpn)))
             || (acc && dev_req_write && (req_line == track_line));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      lat_err   <= 1'b0;
      lat_data  <= '0;
      lat_addr  <= '0;
      lat_write <= 1'b0;
      lat_wdata <= '0;
      pf_pend   <= 1'b0;
      pf_addr   <= '0;
      pf_line   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (dev_req_valid) begin
          lat_write <= dev_req_write;
          lat_wdata <= dev_req_wdata;
          lat_addr  <= {lk_ppn, req_off};
          pf_addr   <= {lk_ppn, nxt_slot, {LINE_BITS{1'b0}}};
          pf_line   <= req_line + LINE_ONE;
          if (!lk_hit || !perm_ok) begin
            lat_err  <= 1'b1;
            lat_data <= '0;
            pf_pend  <= 1'b0;
            state    <= ST_RESP;
          end else if (hold_hit && !dev_req_write) begin
            lat_err  <= 1'b0;
            lat_data <= hold_data;
            pf_pend  <= pf_ok;
            state    <= ST_RESP;
          end else begin
            lat_err  <= 1'b0;
            lat_data <= '0;
            pf_pend  <= pf_ok && !dev_req_write;
            state    <= ST_BUS_REQ;
          end
        end
        ST_BUS_REQ:  if (sys_req_ready) state <= lat_write ? ST_RESP : ST_BUS_WAIT;
        ST_BUS_WAIT: if (sys_rsp_valid) begin
          lat_data <= sys_rsp_rdata;
          state    <= ST_RESP;
        end
        ST_RESP:     if (dev_rsp_ready) state <= pf_pend ? ST_PF_REQ : ST_IDLE;
        ST_PF_REQ:   if (sys_req_ready) state <= ST_PF_WAIT;
        ST_PF_WAIT:  if (sys_rsp_valid) state <= ST_IDLE;
        default:     state <= ST_IDLE;
      endcase
    end
  end

  assign dev_req_ready = (state == ST_IDLE);
  assign dev_rsp_valid = (state == ST_RESP);
  assign dev_rsp_err   = lat_err;
  assign dev_rsp_rdata = lat_data;
  assign sys_req_valid = (state == ST_BUS_REQ) || (state == ST_PF_REQ);
  assign sys_req_write = (state == ST_BUS_REQ) && lat_write;
  assign sys_req_addr  = (state == ST_PF_REQ) ? pf_addr : lat_addr;
  assign sys_req_wdata = lat_wdata;
endmodule

// File: rtl/dma_remap_unit_chk.sv
module dma_remap_unit_chk #(
  parameter int SYS_AW = 40,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dev_req_ready,
  input logic              dev_rsp_valid,
  input logic              dev_rsp_ready,
  input logic              dev_rsp_err,
  input logic [DATA_W-1:0] dev_rsp_rdata,
  input logic              sys_req_valid,
  input logic              sys_req_ready,
  input logic              sys_req_write,
  input logic [SYS_AW-1:0] sys_req_addr,
  input logic [DATA_W-1:0] sys_req_wdata
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> (dev_req_ready && !sys_req_valid && !dev_rsp_valid));

  a_r3_error_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_valid && dev_rsp_err) |-> (dev_rsp_rdata == '0));

  a_r11_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_valid && !dev_rsp_ready) |=>
      (dev_rsp_valid && $stable(dev_rsp_rdata) && $stable(dev_rsp_err)));

  a_r12_sys_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_req_valid && !sys_req_ready) |=>
      (sys_req_valid && $stable(sys_req_addr) && $stable(sys_req_write) && $stable(sys_req_wdata)));
endmodule

bind dma_remap_unit dma_remap_unit_chk #(.SYS_AW(SYS_AW), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/dma_remap_unit_tb_top.sv
`timescale 1ns/1ps
module dma_remap_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        cfg_we = 0;
  logic [3:0]  cfg_idx = 0;
  logic [19:0] cfg_vpn = 0;
  logic [27:0] cfg_ppn = 0;
  logic cfg_valid = 0, cfg_rd_en = 0, cfg_wr_en = 0, cfg_stream = 0;
  logic        dev_req_valid = 0, dev_req_write = 0;
  logic        dev_req_ready;
  logic [31:0] dev_req_addr = 0;
  logic [63:0] dev_req_wdata = 0;
  logic        dev_rsp_valid, dev_rsp_err;
  logic        dev_rsp_ready = 1;
  logic [63:0] dev_rsp_rdata;
  logic        sys_req_valid, sys_req_write;
  logic        sys_req_ready = 0;
  logic [39:0] sys_req_addr;
  logic [63:0] sys_req_wdata;
  logic        sys_rsp_valid = 0;
  logic [63:0] sys_rsp_rdata = 0;

  dma_remap_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vpn(cfg_vpn), .cfg_ppn(cfg_ppn),
    .cfg_valid(cfg_valid), .cfg_rd_en(cfg_rd_en), .cfg_wr_en(cfg_wr_en), .cfg_stream(cfg_stream),
    .dev_req_valid(dev_req_valid), .dev_req_ready(dev_req_ready), .dev_req_write(dev_req_write),
    .dev_req_addr(dev_req_addr), .dev_req_wdata(dev_req_wdata),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_ready(dev_rsp_ready), .dev_rsp_err(dev_rsp_err),
    .dev_rsp_rdata(dev_rsp_rdata),
    .sys_req_valid(sys_req_valid), .sys_req_ready(sys_req_ready), .sys_req_write(sys_req_write),
    .sys_req_addr(sys_req_addr), .sys_req_wdata(sys_req_wdata),
    .sys_rsp_valid(sys_rsp_valid), .sys_rsp_rdata(sys_rsp_rdata)
  );

  int n_chk = 0, n_err = 0;
  int bus_count = 0;
  logic [39:0] hist_addr [64];
  logic        hist_wr   [64];
  logic [63:0] hist_wd   [64];
  logic [19:0] bvpn [16];
  logic [27:0] bppn [16];
  logic brd [16], bwr [16], bstr [16];

  function automatic logic [63:0] memval(input logic [39:0] a);
    return {24'hC0FFEE, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // System bus model: accepts one cycle after a request is seen, read data two cycles later.
  initial begin
    int rsp_wait;
    logic [39:0] cur_addr;
    logic cur_wr;
    rsp_wait = 0;
    cur_addr = '0;
    cur_wr = 1'b0;
    forever begin
      @(negedge clk);
      sys_rsp_valid = 1'b0;
      if (sys_req_ready) begin
        sys_req_ready = 1'b0;
        if (!cur_wr) rsp_wait = 2;
      end else if (sys_req_valid) begin
        sys_req_ready = 1'b1;
        cur_addr = sys_req_addr;
        cur_wr = sys_req_write;
        hist_addr[bus_count % 64] = sys_req_addr;
        hist_wr[bus_count % 64]   = sys_req_write;
        hist_wd[bus_count % 64]   = sys_req_wdata;
        bus_count++;
      end
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          sys_rsp_valid = 1'b1;
          sys_rsp_rdata = memval(cur_addr);
        end
      end
    end
  end

  task automatic cfg(input int i, input logic [19:0] vpn, input logic [27:0] ppn,
                     input bit v, input bit rd, input bit wr, input bit st);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 4'(i); cfg_vpn = vpn; cfg_ppn = ppn;
    cfg_valid = v; cfg_rd_en = rd; cfg_wr_en = wr; cfg_stream = st;
    @(negedge clk);
    cfg_we = 0;
    bvpn[i] = vpn; bppn[i] = ppn; brd[i] = rd; bwr[i] = wr; bstr[i] = st;
  endtask

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [63:0] wd,
                      output bit err, output logic [63:0] rd);
    @(negedge clk);
    while (!dev_req_ready) @(negedge clk);
    dev_req_valid = 1; dev_req_write = wr; dev_req_addr = addr; dev_req_wdata = wd;
    @(negedge clk);
    dev_req_valid = 0;
    while (!dev_rsp_valid) @(negedge clk);
    err = dev_rsp_err;
    rd  = dev_rsp_rdata;
    @(negedge clk);
    while (!dev_req_ready) @(negedge clk);
  endtask

  initial begin
    bit e;
    logic [63:0] d;
    int c0;
    logic [11:0] off;
    logic [39:0] ta;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dev_req_ready && !sys_req_valid && !dev_rsp_valid, "R1 idle after reset",
        {61'd0, dev_req_ready, sys_req_valid, dev_rsp_valid}, 64'h4);
    rst_n = 1;

    // R3: everything misses on an empty table
    c0 = bus_count;
    xfer(0, 32'hFFFFF010, 0, e, d);
    chk(e == 1 && d == 0, "R3 miss error", {63'd0, e}, 64'd1);
    chk(bus_count == c0, "R3 miss no bus", 64'(bus_count - c0), 64'd0);

    // Program all slots: read off for slot 7, write on even slots, streaming on multiples of 4
    for (int i = 0; i < 16; i++)
      cfg(i, 20'h00010 + 20'(i * 5), 28'h1000000 + 28'(i * 28'h111),
          1, (i != 7), (i % 2 == 0), (i % 4 == 0));

    // Read sweep: R2, R4, R5, R6
    for (int i = 0; i < 16; i++) begin
      off = 12'h040 + 12'(i * 8);
      ta = {bppn[i], off};
      c0 = bus_count;
      xfer(0, {bvpn[i], off}, 0, e, d);
      if (!brd[i]) begin
        chk(e == 1, "R4 read not permitted", {63'd0, e}, 64'd1);
        chk(bus_count == c0, "R4 no bus on read error", 64'(bus_count - c0), 64'd0);
      end else begin
        chk(e == 0 && d == memval(ta), "R2 read data", d, memval(ta));
        chk(hist_addr[c0 % 64] == ta, "R2 translated address", 64'(hist_addr[c0 % 64]), 64'(ta));
        if (bstr[i]) begin
          chk(bus_count == c0 + 2, "R6 read-ahead issued", 64'(bus_count - c0), 64'd2);
          chk(hist_addr[(c0 + 1) % 64] == ta + 40'd8, "R6 read-ahead address",
              64'(hist_addr[(c0 + 1) % 64]), 64'(ta + 40'd8));
        end else begin
          chk(bus_count == c0 + 1, "R5 consistent single read", 64'(bus_count - c0), 64'd1);
        end
      end
    end

    // Write sweep: R12, R4
    for (int i = 0; i < 16; i++) begin
      ta = {bppn[i], 12'h100};
      c0 = bus_count;
      xfer(1, {bvpn[i], 12'h100}, 64'hD000 + 64'(i), e, d);
      if (bwr[i]) begin
        chk(e == 0 && bus_count == c0 + 1, "R12 write issued", 64'(bus_count - c0), 64'd1);
        chk(hist_wr[c0 % 64] && hist_addr[c0 % 64] == ta, "R12 write address",
            64'(hist_addr[c0 % 64]), 64'(ta));
        chk(hist_wd[c0 % 64] == 64'hD000 + 64'(i), "R12 write data",
            hist_wd[c0 % 64], 64'hD000 + 64'(i));
      end else begin
        chk(e == 1 && bus_count == c0, "R4 write not permitted", 64'(bus_count - c0), 64'd0);
      end
    end

    // R7: sequential streaming reads on slot 4
    c0 = bus_count;
    xfer(0, {bvpn[4], 12'h200}, 0, e, d);
    chk(bus_count == c0 + 2, "R6 stream first line", 64'(bus_count - c0), 64'd2);
    c0 = bus_count;
    xfer(0, {bvpn[4], 12'h208}, 0, e, d);
    chk(d == memval({bppn[4], 12'h208}), "R7 held data", d, memval({bppn[4], 12'h208}));
    chk(bus_count == c0 + 1, "R7 only next read-ahead", 64'(bus_count - c0), 64'd1);
    chk(hist_addr[c0 % 64] == {bppn[4], 12'h210}, "R7 chained read-ahead address",
        64'(hist_addr[c0 % 64]), 64'({bppn[4], 12'h210}));

    // R8: last line of a page
    c0 = bus_count;
    xfer(0, {bvpn[8], 12'hFF8}, 0, e, d);
    chk(bus_count == c0 + 1, "R8 no read-ahead at page end", 64'(bus_count - c0), 64'd1);

    // R9: remapping the held page discards the held line
    cfg(4, bvpn[4], 28'hABCDE12, 1, 1, 1, 1);
    c0 = bus_count;
    xfer(0, {bvpn[4], 12'h210}, 0, e, d);
    chk(d == memval({28'hABCDE12, 12'h210}), "R9 remap data", d, memval({28'hABCDE12, 12'h210}));
    chk(bus_count == c0 + 2, "R9 remap goes to bus", 64'(bus_count - c0), 64'd2);

    // R9: device write onto the held line discards it
    xfer(0, {bvpn[12], 12'h300}, 0, e, d);
    xfer(1, {bvpn[12], 12'h308}, 64'h55, e, d);
    c0 = bus_count;
    xfer(0, {bvpn[12], 12'h308}, 0, e, d);
    chk(bus_count == c0 + 2, "R9 write discards held line", 64'(bus_count - c0), 64'd2);
    chk(hist_addr[c0 % 64] == {bppn[12], 12'h308}, "R9 refetch address",
        64'(hist_addr[c0 % 64]), 64'({bppn[12], 12'h308}));

    // R5: sequential reads in a consistent slot
    c0 = bus_count;
    xfer(0, {bvpn[2], 12'h500}, 0, e, d);
    xfer(0, {bvpn[2], 12'h508}, 0, e, d);
    chk(bus_count == c0 + 2, "R5 sequential consistent", 64'(bus_count - c0), 64'd2);
    chk(d == memval({bppn[2], 12'h508}), "R5 sequential data", d, memval({bppn[2], 12'h508}));

    // R10: overlapping slots, lowest index wins
    cfg(14, bvpn[3], 28'h7777777, 1, 1, 1, 0);
    xfer(0, {bvpn[3], 12'h010}, 0, e, d);
    chk(d == memval({bppn[3], 12'h010}), "R10 lower slot wins", d, memval({bppn[3], 12'h010}));
    cfg(3, bvpn[3], bppn[3], 0, 1, 0, 0);
    xfer(0, {bvpn[14], 12'h010}, 0, e, d);
    chk(d == memval({28'h7777777, 12'h010}), "R10 higher slot after drop", d,
        memval({28'h7777777, 12'h010}));

    // R11: response held back by the device
    dev_rsp_ready = 0;
    @(negedge clk);
    while (!dev_req_ready) @(negedge clk);
    dev_req_valid = 1; dev_req_write = 0; dev_req_addr = {bvpn[2], 12'h600};
    @(negedge clk);
    dev_req_valid = 0;
    while (!dev_rsp_valid) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(dev_rsp_valid && !dev_req_ready, "R11 response held", {62'd0, dev_rsp_valid, dev_req_ready}, 64'h2);
    chk(dev_rsp_rdata == memval({bppn[2], 12'h600}), "R11 held data", dev_rsp_rdata,
        memval({bppn[2], 12'h600}));
    dev_rsp_ready = 1;
    @(negedge clk);
    chk(!dev_rsp_valid && dev_req_ready, "R11 released", {62'd0, dev_rsp_valid, dev_req_ready}, 64'h1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule